// File: doc/BRIEF.md
# SMM Memory Window Access Controller

This block holds the control byte that governs the 128 KB system-management DRAM window at 0xA0000–0xBFFFF. For each host memory access it decides whether the access reaches that DRAM or is forwarded to the PCI bus. Software programs the control byte through a plain config-write port. The byte has a global enable, an open bit, a closed bit and a sticky lock. The lock can be set by an ordinary write, and only a power-on reset clears it. While it is set, the other control bits of the block that belong to the locked set become read-only. The lock is also exported so that neighbouring registers can protect themselves.

Host accesses enter on a valid/ready request channel and come back one cycle later on a valid/ready response channel. The response carries the routing decision and the unchanged address, because the window is made visible and never remapped. Back-pressure works as follows. A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response stage is empty or is being drained in the same cycle. A response that is not taken stays on the pins, unchanged, until `rsp_ready` is high.

Top module: `smm_window_ctl`

## Requirements
- R1: After power-on reset the control byte at config offset 0x72 reads 0x02, `smm_lock` is 0 and `rsp_valid` is 0.
- R2: In the control byte, bits 2:0 always read 3'b010 and bit 7 always reads 0. Writes to these bits are ignored.
- R3: The control byte maps bit 3 as the global enable, bit 4 as lock, bit 5 as closed and bit 6 as open. While the global enable is 0, every access to the window is routed to PCI, whatever the open bit and the SMM flag hold.
- R4: With the global enable at 1 and `ext_win_en` at 0, an SMM-mode data access to the window goes to DRAM and a non-SMM access goes to PCI. With `ext_win_en` at 1, every window access goes to PCI.
- R5: With open at 1 and lock at 0, and the window active, a non-SMM access to the window goes to DRAM.
- R6: With closed at 1 and the window active, an SMM data access (`req_code`=0) goes to PCI and an SMM code fetch (`req_code`=1) goes to DRAM.
- R7: A write with bit 4 at 1 sets lock and `smm_lock`. While the byte is locked, writes cannot change the open, lock or global-enable bits, the open bit reads 0, and the closed bit stays writable. Only `rst_n` clears the lock.
- R8: A single write that sets both lock and open stores open as 0.
- R9: An access outside 0xA0000–0xBFFFF returns `rsp_hit`, `rsp_to_dram` and `rsp_to_pci` all at 0. A window access asserts `rsp_hit` and exactly one of the two routes.
- R10: `rsp_addr` equals the `req_addr` of the accepted request.
- R11: An accepted request gives `rsp_valid` in the next cycle. While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and the response is held stable.
- R12: Writes to config offsets other than 0x72 leave the control byte unchanged, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config byte address for write and read |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data at `cfg_addr` (combinational) |
| ext_win_en | input | 1 | Extended window enable; disables the compatible window |
| smm_lock | output | 1 | Lock state, for protecting neighbouring registers |
| req_valid | input | 1 | Host access request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 32 | Host address |
| req_smm | input | 1 | Access made in SMM mode |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_addr | output | 32 | DRAM/PCI address (equal to host address) |
| rsp_hit | output | 1 | Address lies inside the window |
| rsp_to_dram | output | 1 | Route to system-management DRAM |
| rsp_to_pci | output | 1 | Forward to PCI |

## Verification
The decode is tried with each combination of SMM flag and code/data flag under each control setting: disabled, compatible, open, closed, locked, and the extended window taking over. Each pattern isolates one term of the routing equation. Addresses just below and just above the window separate the "not decoded" case from "forwarded to PCI". Writes made after the lock, including one that sets lock and open together, show which bits froze and which stayed writable. A stalled response with a second request pending separates holding the response from overwriting it.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int CFG_DW     = 8;
  localparam int BIT_GEN    = 3;
  localparam int BIT_LOCK   = 4;
  localparam int BIT_CLOSED = 5;
  localparam int BIT_OPEN   = 6;
  localparam int BIT_RSVD   = 7;
  localparam logic [2:0] BASE_SEG_CODE = 3'b010;

  typedef struct packed {
    logic open;
    logic closed;
    logic lock;
    logic gen;
  } smm_ctl_t;

  localparam smm_ctl_t CTL_RESET = '{open: 1'b0, closed: 1'b0, lock: 1'b0, gen: 1'b0};

  typedef struct packed {
    logic hit;
    logic to_dram;
    logic to_pci;
  } smm_route_t;
endpackage

// File: rtl/smm_cfg_reg.sv
module smm_cfg_reg
  import smm_pkg::*;
#(
  parameter int               CFG_AW = 8,
  parameter logic [CFG_AW-1:0] OFFSET = 8'h72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output smm_ctl_t          ctl
);
  logic sel;
  logic unused_wbits;

  assign sel          = (addr == OFFSET);
  assign unused_wbits = ^{wdata[BIT_RSVD], wdata[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_RESET;
    end else if (wr_en && sel) begin
      ctl.closed <= wdata[BIT_CLOSED];
      if (!ctl.lock) begin
        ctl.gen  <= wdata[BIT_GEN];
        ctl.lock <= wdata[BIT_LOCK];
        ctl.open <= wdata[BIT_OPEN] & ~wdata[BIT_LOCK];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[2:0]        = BASE_SEG_CODE;
      rdata[BIT_GEN]    = ctl.gen;
      rdata[BIT_LOCK]   = ctl.lock;
      rdata[BIT_CLOSED] = ctl.closed;
      rdata[BIT_OPEN]   = ctl.open;
    end
  end
endmodule

// File: rtl/smm_window_decode.sv
module smm_window_decode
  import smm_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter int                WIN_LOG2 = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic              code,
  input  logic              ext_en,
  input  smm_ctl_t          ctl,
  output smm_route_t        route
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic in_win;
  logic active;
  logic open_ok;
  logic smm_ok;
  logic grant;

  assign in_win  = (addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign active  = ctl.gen & ~ext_en;
  assign open_ok = ctl.open & ~ctl.lock;
  assign smm_ok  = smm & (~ctl.closed | code);
  assign grant   = active & (open_ok | smm_ok);

  always_comb begin
    route.hit     = in_win;
    route.to_dram = in_win & grant;
    route.to_pci  = in_win & ~grant;
  end
endmodule

// File: rtl/smm_rsp_stage.sv
module smm_rsp_stage
  import smm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  smm_route_t        in_route,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output smm_route_t        out_route
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_route <= '0;
    end else if (take) begin
      out_addr  <= in_addr;
      out_route <= in_route;
    end
  end
endmodule

// File: rtl/smm_window_ctl.sv
module smm_window_ctl
  import smm_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                CFG_AW     = 8,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h72,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h000A_0000,
  parameter int                WIN_LOG2   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              ext_win_en,
  output logic              smm_lock,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_smm,
  input  logic              req_code,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_hit,
  output logic              rsp_to_dram,
  output logic              rsp_to_pci
);
  smm_ctl_t   ctl;
  smm_route_t route_d;
  smm_route_t route_q;

  smm_cfg_reg #(.CFG_AW(CFG_AW), .OFFSET(CTL_OFFSET)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctl(ctl)
  );

  smm_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_dec (
    .addr(req_addr), .smm(req_smm), .code(req_code), .ext_en(ext_win_en),
    .ctl(ctl), .route(route_d)
  );

  smm_rsp_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_addr(req_addr), .in_route(route_d),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_addr(rsp_addr), .out_route(route_q)
  );

  assign smm_lock    = ctl.lock;
  assign rsp_hit     = route_q.hit;
  assign rsp_to_dram = route_q.to_dram;
  assign rsp_to_pci  = route_q.to_pci;
endmodule

// File: rtl/smm_window_chk.sv
module smm_window_chk #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              ext_win_en,
  input logic              smm_lock,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_smm,
  input logic              req_code,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_hit,
  input logic              rsp_to_dram,
  input logic              rsp_to_pci
);
  logic unused_chk;
  assign unused_chk = ^{cfg_wr_en, cfg_wdata, ext_win_en, req_smm, req_code};

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smm_lock |=> smm_lock);

  // R7
  locked_open_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_lock && cfg_addr == CTL_OFFSET) |-> cfg_rdata[6] == 1'b0);

  // R9
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_to_dram, rsp_to_pci}) == (rsp_hit ? 1 : 0)));

  // R10
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid && rsp_addr == $past(req_addr)));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
                                   && $stable(rsp_to_dram) && $stable(rsp_to_pci)));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind smm_window_ctl smm_window_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .CTL_OFFSET(CTL_OFFSET)) u_chk (.*);

// File: tb/sim_smm_window_ctl.sv
module sim_smm_window_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h72;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        ext_win_en = 1'b0;
  logic        smm_lock;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_smm = 1'b0;
  logic        req_code = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_hit, rsp_to_dram, rsp_to_pci;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smm_window_ctl u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_addr = 8'h72;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_addr = 8'h72;
  endtask

  // returns {hit, dram, pci}; also checks response timing and address
  task automatic access(input string tag, input logic [31:0] a, input logic smm,
                        input logic code, input logic [2:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_smm = smm; req_code = code;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R11 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " R10 rsp_addr"}, rsp_addr, a);
    check(tag, {29'b0, rsp_hit, rsp_to_dram, rsp_to_pci}, {29'b0, exp});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    cfg_read(8'h72, d);
    check("R1 reset value", {24'b0, d}, 32'h02);
    check("R1 lock at reset", {31'b0, smm_lock}, 32'd0);
    check("R1 rsp_valid at reset", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_ro_fields;
    logic [7:0] d;
    cfg_write(8'h72, 8'h87);
    cfg_read(8'h72, d);
    check("R2 ro bits ignored", {24'b0, d}, 32'h02);
    cfg_write(8'h72, 8'h8D);
    cfg_read(8'h72, d);
    check("R2 ro bits with gen", {24'b0, d}, 32'h0A);
    cfg_write(8'h72, 8'h00);
  endtask

  task automatic t_other_offset;
    logic [7:0] d;
    cfg_write(8'h71, 8'h48);
    cfg_write(8'h73, 8'h08);
    cfg_read(8'h72, d);
    check("R12 other offset write", {24'b0, d}, 32'h02);
    cfg_read(8'h71, d);
    check("R12 other offset read", {24'b0, d}, 32'h00);
  endtask

  task automatic t_gen_off;
    cfg_write(8'h72, 8'h40);
    access("R3 gen off smm", 32'h000A_0000, 1'b1, 1'b0, 3'b101);
    access("R3 gen off open nonsmm", 32'h000B_FFFF, 1'b0, 1'b0, 3'b101);
  endtask

  task automatic t_compat;
    cfg_write(8'h72, 8'h08);
    access("R4 smm data", 32'h000B_0000, 1'b1, 1'b0, 3'b110);
    access("R4 nonsmm", 32'h000B_0000, 1'b0, 1'b0, 3'b101);
    ext_win_en = 1'b1;
    access("R4 ext window on", 32'h000A_8000, 1'b1, 1'b0, 3'b101);
    ext_win_en = 1'b0;
  endtask

  task automatic t_open;
    cfg_write(8'h72, 8'h48);
    access("R5 open nonsmm", 32'h000A_1234, 1'b0, 1'b0, 3'b110);
  endtask

  task automatic t_closed;
    cfg_write(8'h72, 8'h28);
    access("R6 closed smm data", 32'h000A_4000, 1'b1, 1'b0, 3'b101);
    access("R6 closed smm code", 32'h000A_4000, 1'b1, 1'b1, 3'b110);
    access("R6 closed nonsmm code", 32'h000A_4000, 1'b0, 1'b1, 3'b101);
  endtask

  task automatic t_outside;
    cfg_write(8'h72, 8'h48);
    access("R9 below window", 32'h0009_FFFF, 1'b1, 1'b0, 3'b000);
    access("R9 above window", 32'h000C_0000, 1'b1, 1'b1, 3'b000);
    access("R9 high alias", 32'h100A_0000, 1'b1, 1'b0, 3'b000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h000A_0010; req_smm = 1'b1; req_code = 1'b0;
    @(negedge clk);
    check("R11 valid after accept", {31'b0, rsp_valid}, 32'd1);
    check("R11 ready low in stall", {31'b0, req_ready}, 32'd0);
    req_addr = 32'h000C_0020;
    @(negedge clk);
    check("R11 held addr", rsp_addr, 32'h000A_0010);
    check("R11 held route", {29'b0, rsp_hit, rsp_to_dram, rsp_to_pci}, 32'b110);
    rsp_ready = 1'b1;
    #1 check("R11 ready when drained", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next addr", rsp_addr, 32'h000C_0020);
    check("R11 next route", {29'b0, rsp_hit, rsp_to_dram, rsp_to_pci}, 32'b000);
    @(negedge clk);
    check("R11 drained", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_lock_both;
    logic [7:0] d;
    cfg_write(8'h72, 8'h58);
    cfg_read(8'h72, d);
    check("R8 lock and open together", {24'b0, d}, 32'h1A);
    check("R7 lock output", {31'b0, smm_lock}, 32'd1);
    access("R8 open not effective", 32'h000A_0000, 1'b0, 1'b0, 3'b101);
  endtask

  task automatic t_locked_ro;
    logic [7:0] d;
    cfg_write(8'h72, 8'h40);
    cfg_read(8'h72, d);
    check("R7 locked bits frozen", {24'b0, d}, 32'h1A);
    cfg_write(8'h72, 8'h60);
    cfg_read(8'h72, d);
    check("R7 closed writable when locked", {24'b0, d}, 32'h3A);
    access("R7 locked closed smm data", 32'h000A_0000, 1'b1, 1'b0, 3'b101);
    access("R7 locked smm code", 32'h000A_0000, 1'b1, 1'b1, 3'b110);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_read(8'h72, d);
    check("R7 reset clears lock", {24'b0, d}, 32'h02);
    check("R7 lock output after reset", {31'b0, smm_lock}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ro_fields();
    t_other_offset();
    t_gen_off();
    t_compat();
    t_open();
    t_closed();
    t_outside();
    t_backpressure();
    t_lock_both();
    t_locked_ro();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule